// File: doc/BRIEF.md
# Partition Time-Slice Watchdog with Tiered Escalation

This block guards a set of partition queues on a compute device. Each partition owns a time-slice counter that restarts whenever its scheduler reports a kernel start or a preemption point. When a slice runs out, or when the partition raises a forbidden-operation flag, the block asks for that partition to be preempted. If the preemption is not acknowledged within a programmable grace period, the block pulses a reset to that partition alone. The other partitions keep running through all of this.

A single global watchdog sits above the partitions. Only kicks tagged as coming from the security core restart it. If it runs out, it raises a device-wide reset that stays high until the block's own reset. Kicks from any other source have no effect on the global watchdog. They are counted in a saturating sticky error counter. Every preemption request is also pulsed on a per-partition event output, so a higher-level controller can log it.

Limits are loaded through a small write port. The slice limit is set per partition. The grace limit is shared by all partitions. The global limit is a single value.

Top module: `part_wdt_top`

## Requirements
- R1: After reset, preemptReq, partReset, timeoutEvt and deviceReset are all 0, kickErrCount is 0, and every partition is idle.
- R2: A write with cfgSel=0 sets the slice limit L of partition cfgPart. If partStart of that partition is high at edge E0 and then stays low, preemptReq of that partition is 0 after edges E0..E0+L and rises after edge E0+L+1.
- R3: An idle partition never times out. A running partition that gets partStart again at least every L cycles never raises preemptReq.
- R4: A forbidden-operation flag seen at an edge while the partition is running raises preemptReq after that same edge. The flag has no effect on an idle partition.
- R5: A write with cfgSel=1 sets the shared grace limit G. If preemptAck is high at any of the G+1 edges after preemptReq rises, including the last one, the partition returns to idle and no partReset is raised.
- R6: Without an acknowledge, partReset of that partition is high for exactly one cycle. It rises G+1 edges after preemptReq rose, and preemptReq falls at that same edge. preemptReq and partReset are never both high.
- R7: Timeouts, preemptions and resets of one partition leave the outputs of the other partitions unchanged.
- R8: timeoutEvt of a partition is a one-cycle pulse that coincides with the first cycle of each preemptReq, whether a slice expiry or a forbidden flag caused it.
- R9: A write with cfgSel=2 sets the global limit GL. A kick with gKickSecure=1 restarts the global watchdog. deviceReset is 0 after edges K..K+GL following the last secure kick at edge K, rises after edge K+GL+1, and then stays high until rstN.
- R10: A kick with gKickSecure=0 does not restart the global watchdog. Each such kick adds one to kickErrCount, which saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select: 0 slice limit, 1 grace limit, 2 global limit |
| cfgPart | input | PIDX_W | Partition index for slice-limit writes |
| cfgData | input | CFG_W | Value to write |
| partStart | input | NP | Kernel start or preemption point, one bit per partition |
| partForbid | input | NP | Forbidden-operation flag, one bit per partition |
| preemptAck | input | NP | Scheduler acknowledge of a preemption |
| gKick | input | 1 | Global watchdog kick |
| gKickSecure | input | 1 | Kick comes from the security core |
| preemptReq | output | NP | Preemption request, per partition |
| partReset | output | NP | One-cycle partition reset |
| timeoutEvt | output | NP | One-cycle event when a preemption begins |
| deviceReset | output | 1 | Sticky device-wide reset |
| kickErrCount | output | ERR_W | Saturating count of non-secure kicks |

## Verification
The assertions take for granted that preemptAck is raised only while the matching preemptReq is high. They also take for granted that partStart and partForbid are single-cycle pulses from the scheduler. A forbidden flag that stays high while a partition runs would only re-trigger the same preemption. The stimulus drives every input as a one-cycle pulse just after a clock edge and raises acknowledges only during a preemption window. While the partition sweep runs, a background secure kicker keeps the global watchdog far from its limit, so a device reset never hides a partition result.

// File: rtl/part_wdt_pkg.sv
package part_wdt_pkg;

  typedef enum logic [1:0] {
    P_IDLE = 2'd0,
    P_RUN  = 2'd1,
    P_PRE  = 2'd2,
    P_RST  = 2'd3
  } partState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic graceClr;
    logic graceInc;
  } partStrobe_t;

  typedef struct packed {
    logic gClr;
    logic gInc;
    logic errInc;
  } globStrobe_t;

endpackage

// File: rtl/part_wdt_datapath.sv
module part_wdt_datapath
  import part_wdt_pkg::*;
#(
  parameter int NP         = 4,
  parameter int SLICE_W    = 12,
  parameter int GRACE_W    = 6,
  parameter int GWD_W      = 12,
  parameter int ERR_W      = 8,
  parameter int CFG_W      = 12,
  parameter int PIDX_W     = 2,
  parameter int SLICE_INIT = 1000,
  parameter int GRACE_INIT = 16,
  parameter int GWD_INIT   = 3000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWe,
  input  logic [1:0]             cfgSel,
  input  logic [PIDX_W-1:0]      cfgPart,
  input  logic [CFG_W-1:0]       cfgData,
  input  partStrobe_t [NP-1:0]   ps,
  input  globStrobe_t            gs,
  output logic [NP-1:0]          sliceHit,
  output logic [NP-1:0]          graceHit,
  output logic                   gHit,
  output logic [ERR_W-1:0]       errCount
);

  logic [GRACE_W-1:0] graceLim;
  logic [GWD_W-1:0]   gLim;
  logic [GWD_W-1:0]   gCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      graceLim <= GRACE_W'(GRACE_INIT);
      gLim     <= GWD_W'(GWD_INIT);
    end else if (cfgWe) begin
      if (cfgSel == 2'd1) graceLim <= cfgData[GRACE_W-1:0];
      if (cfgSel == 2'd2) gLim     <= cfgData[GWD_W-1:0];
    end
  end

  for (genvar p = 0; p < NP; p++) begin : gPart
    logic [SLICE_W-1:0] sliceLim;
    logic [SLICE_W-1:0] sliceCnt;
    logic [GRACE_W-1:0] graceCnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        sliceLim <= SLICE_W'(SLICE_INIT);
      end else if (cfgWe && cfgSel == 2'd0 && cfgPart == PIDX_W'(p)) begin
        sliceLim <= cfgData[SLICE_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        sliceCnt <= '0;
        graceCnt <= '0;
      end else begin
        if (ps[p].cntClr)        sliceCnt <= '0;
        else if (ps[p].cntInc)   sliceCnt <= sliceCnt + 1'b1;
        if (ps[p].graceClr)      graceCnt <= '0;
        else if (ps[p].graceInc) graceCnt <= graceCnt + 1'b1;
      end
    end

    assign sliceHit[p] = (sliceCnt >= sliceLim);
    assign graceHit[p] = (graceCnt >= graceLim);

    AST_SLICE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
      ps[p].cntClr |=> (sliceCnt == '0)); // R2
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gCnt     <= '0;
      errCount <= '0;
    end else begin
      if (gs.gClr)      gCnt <= '0;
      else if (gs.gInc) gCnt <= gCnt + 1'b1;
      if (gs.errInc && errCount != {ERR_W{1'b1}}) errCount <= errCount + 1'b1;
    end
  end

  assign gHit = (gCnt >= gLim);

  AST_ERR_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == {ERR_W{1'b1}}) |=> (errCount == {ERR_W{1'b1}})); // R10

  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !gs.errInc |=> $stable(errCount)); // R10

endmodule

// File: rtl/part_wdt_control.sv
module part_wdt_control
  import part_wdt_pkg::*;
#(
  parameter int NP = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NP-1:0]        partStart,
  input  logic [NP-1:0]        partForbid,
  input  logic [NP-1:0]        preemptAck,
  input  logic                 gKick,
  input  logic                 gKickSecure,
  input  logic [NP-1:0]        sliceHit,
  input  logic [NP-1:0]        graceHit,
  input  logic                 gHit,
  output partStrobe_t [NP-1:0] ps,
  output globStrobe_t          gs,
  output logic [NP-1:0]        preemptReq,
  output logic [NP-1:0]        partReset,
  output logic [NP-1:0]        timeoutEvt,
  output logic                 deviceReset
);

  for (genvar p = 0; p < NP; p++) begin : gFsm
    partState_t  st;
    partState_t  nx;
    partStrobe_t s;
    logic        evtNext;
    logic        evtQ;

    always_comb begin
      nx      = st;
      s       = '0;
      evtNext = 1'b0;
      case (st)
        P_IDLE: begin
          if (partStart[p]) begin
            s.cntClr = 1'b1;
            nx       = P_RUN;
          end
        end
        P_RUN: begin
          if (partForbid[p] || (sliceHit[p] && !partStart[p])) begin
            nx         = P_PRE;
            s.graceClr = 1'b1;
            evtNext    = 1'b1;
          end else if (partStart[p]) begin
            s.cntClr = 1'b1;
          end else begin
            s.cntInc = 1'b1;
          end
        end
        P_PRE: begin
          if (preemptAck[p])     nx = P_IDLE;
          else if (graceHit[p])  nx = P_RST;
          else                   s.graceInc = 1'b1;
        end
        default: nx = P_IDLE;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        st   <= P_IDLE;
        evtQ <= 1'b0;
      end else begin
        st   <= nx;
        evtQ <= evtNext;
      end
    end

    assign ps[p]         = s;
    assign preemptReq[p] = (st == P_PRE);
    assign partReset[p]  = (st == P_RST);
    assign timeoutEvt[p] = evtQ;

    AST_PREEMPT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(preemptReq[p]) |-> $past(sliceHit[p] || partForbid[p])); // R2
    AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(partReset[p]) |-> ($past(preemptReq[p]) && !$past(preemptAck[p]))); // R6
    AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!rstN)
      partReset[p] |=> !partReset[p]); // R6
    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rstN)
      !(preemptReq[p] && partReset[p])); // R6
    AST_EVT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
      timeoutEvt[p] |-> ($rose(preemptReq[p]) && !$past(timeoutEvt[p]))); // R8
  end

  logic kickOk;
  assign kickOk = gKick && gKickSecure;

  always_comb begin
    gs        = '0;
    gs.errInc = gKick && !gKickSecure;
    if (!deviceReset) begin
      if (kickOk) gs.gClr = 1'b1;
      else        gs.gInc = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                deviceReset <= 1'b0;
    else if (!deviceReset && !kickOk && gHit) deviceReset <= 1'b1;
  end

  AST_DEVRST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    deviceReset |=> deviceReset); // R9
  AST_DEVRST_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(deviceReset) |-> $past(gHit && !(gKick && gKickSecure))); // R9

endmodule

// File: rtl/part_wdt_top.sv
module part_wdt_top
  import part_wdt_pkg::*;
#(
  parameter int NP         = 4,
  parameter int SLICE_W    = 12,
  parameter int GRACE_W    = 6,
  parameter int GWD_W      = 12,
  parameter int ERR_W      = 8,
  parameter int SLICE_INIT = 1000,
  parameter int GRACE_INIT = 16,
  parameter int GWD_INIT   = 3000,
  localparam int PIDX_W    = (NP > 1) ? $clog2(NP) : 1,
  localparam int CFG_A     = (SLICE_W > GRACE_W) ? SLICE_W : GRACE_W,
  localparam int CFG_W     = (CFG_A > GWD_W) ? CFG_A : GWD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [PIDX_W-1:0] cfgPart,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic [NP-1:0]     partStart,
  input  logic [NP-1:0]     partForbid,
  input  logic [NP-1:0]     preemptAck,
  input  logic              gKick,
  input  logic              gKickSecure,
  output logic [NP-1:0]     preemptReq,
  output logic [NP-1:0]     partReset,
  output logic [NP-1:0]     timeoutEvt,
  output logic              deviceReset,
  output logic [ERR_W-1:0]  kickErrCount
);

  partStrobe_t [NP-1:0] ps;
  globStrobe_t          gs;
  logic [NP-1:0]        sliceHit;
  logic [NP-1:0]        graceHit;
  logic                 gHit;

  part_wdt_control #(.NP(NP)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .partStart(partStart), .partForbid(partForbid), .preemptAck(preemptAck),
    .gKick(gKick), .gKickSecure(gKickSecure),
    .sliceHit(sliceHit), .graceHit(graceHit), .gHit(gHit),
    .ps(ps), .gs(gs),
    .preemptReq(preemptReq), .partReset(partReset), .timeoutEvt(timeoutEvt),
    .deviceReset(deviceReset)
  );

  part_wdt_datapath #(
    .NP(NP), .SLICE_W(SLICE_W), .GRACE_W(GRACE_W), .GWD_W(GWD_W),
    .ERR_W(ERR_W), .CFG_W(CFG_W), .PIDX_W(PIDX_W),
    .SLICE_INIT(SLICE_INIT), .GRACE_INIT(GRACE_INIT), .GWD_INIT(GWD_INIT)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgPart(cfgPart), .cfgData(cfgData),
    .ps(ps), .gs(gs),
    .sliceHit(sliceHit), .graceHit(graceHit), .gHit(gHit),
    .errCount(kickErrCount)
  );

endmodule

// File: tb/sim_part_wdt_top.sv
`timescale 1ns/1ps
module sim_part_wdt_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = 2'd0;
  logic [1:0]  cfgPart = 2'd0;
  logic [11:0] cfgData = '0;
  logic [3:0]  partStart = '0;
  logic [3:0]  partForbid = '0;
  logic [3:0]  preemptAck = '0;
  logic        kA = 1'b0;
  logic        kB = 1'b0;
  logic        secB = 1'b0;
  logic        gKick;
  logic        gKickSecure;
  logic [3:0]  preemptReq;
  logic [3:0]  partReset;
  logic [3:0]  timeoutEvt;
  logic        deviceReset;
  logic [7:0]  kickErrCount;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit kickerOn = 1'b1;
  int kcnt = 0;

  assign gKick       = kA | kB;
  assign gKickSecure = kA | secB;

  always #5 clk = ~clk;

  part_wdt_top u0 (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgPart(cfgPart), .cfgData(cfgData),
    .partStart(partStart), .partForbid(partForbid), .preemptAck(preemptAck),
    .gKick(gKick), .gKickSecure(gKickSecure),
    .preemptReq(preemptReq), .partReset(partReset), .timeoutEvt(timeoutEvt),
    .deviceReset(deviceReset), .kickErrCount(kickErrCount)
  );

  // background secure kicker keeps the global watchdog alive
  initial begin
    forever begin
      @(posedge clk);
      #1;
      kcnt++;
      kA = kickerOn && (kcnt % 64 == 0);
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkOthers(input string tag, input int p);
    logic [3:0] m;
    m = ~(4'b1 << p);
    chk(tag, int'((preemptReq | partReset | timeoutEvt) & m), 0);
  endtask

  task automatic cfgWrite(input int sel, input int part, input int data);
    cfgWe = 1'b1; cfgSel = 2'(sel); cfgPart = 2'(part); cfgData = 12'(data);
    tick(1);
    cfgWe = 1'b0;
  endtask

  task automatic startPulse(input int p);
    partStart = 4'b1 << p;
    tick(1);
    partStart = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lims[4];
    int gras[3];
    lims = '{0, 1, 3, 7};
    gras = '{0, 2, 5};
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 preemptReq", int'(preemptReq), 0);
    chk("R1 partReset", int'(partReset), 0);
    chk("R1 timeoutEvt", int'(timeoutEvt), 0);
    chk("R1 deviceReset", int'(deviceReset), 0);
    chk("R1 kickErrCount", int'(kickErrCount), 0);

    // R3 idle partitions never time out; R4 forbid ignored while idle
    cfgWrite(0, 2, 0);
    partForbid = 4'b0100;
    tick(60);
    partForbid = '0;
    chk("R3 idle no preempt", int'(preemptReq), 0);
    chk("R4 idle forbid ignored", int'(timeoutEvt | partReset), 0);

    // R2 R6 R7 R8 sweep of slice and grace limits on every partition
    for (int p = 0; p < 4; p++) begin
      for (int li = 0; li < 4; li++) begin
        for (int gi = 0; gi < 3; gi++) begin
          int l;
          int g;
          l = lims[li];
          g = gras[gi];
          cfgWrite(0, p, l);
          cfgWrite(1, 0, g);
          startPulse(p);
          tick(l);
          chk("R2 before expiry", int'(preemptReq[p]), 0);
          tick(1);
          chk("R2 preempt at expiry", int'(preemptReq[p]), 1);
          chk("R8 event pulse", int'(timeoutEvt[p]), 1);
          chkOthers("R7 others quiet", p);
          tick(g);
          chk("R6 still preempting", int'(preemptReq[p]), 1);
          chk("R6 no early reset", int'(partReset[p]), 0);
          if (g > 0) chk("R8 event single", int'(timeoutEvt[p]), 0);
          tick(1);
          chk("R6 reset pulse", int'(partReset[p]), 1);
          chk("R6 preempt dropped", int'(preemptReq[p]), 0);
          chkOthers("R7 others quiet", p);
          tick(1);
          chk("R6 reset one cycle", int'(partReset[p]), 0);
        end
      end
    end

    // R3 R7 keep-alive on partition 1 while partition 0 escalates
    cfgWrite(0, 0, 3);
    cfgWrite(0, 1, 5);
    cfgWrite(1, 0, 2);
    partStart = 4'b0011;
    tick(1);
    partStart = '0;
    for (int i = 1; i <= 40; i++) begin
      partStart = (i % 4 == 0) ? 4'b0010 : 4'b0000;
      tick(1);
      partStart = '0;
      chk("R3 keep-alive", int'(preemptReq[1] | partReset[1]), 0);
      chk("R7 p0 preempt window", int'(preemptReq[0]), (i >= 4 && i <= 6) ? 1 : 0);
      chk("R7 p0 reset timing", int'(partReset[0]), (i == 7) ? 1 : 0);
    end
    preemptAck = 4'b0010;
    tick(10);
    preemptAck = '0;
    tick(1);
    chk("R5 p1 idle after ack", int'(preemptReq[1] | partReset[1]), 0);

    // R4 forbid while running, R5 immediate ack
    cfgWrite(0, 2, 100);
    cfgWrite(1, 0, 5);
    startPulse(2);
    tick(2);
    partForbid = 4'b0100;
    tick(1);
    partForbid = '0;
    chk("R4 forbid preempts", int'(preemptReq[2]), 1);
    chk("R8 forbid event", int'(timeoutEvt[2]), 1);
    preemptAck = 4'b0100;
    tick(1);
    preemptAck = '0;
    chk("R5 ack idles", int'(preemptReq[2]), 0);
    tick(8);
    chk("R5 no reset after ack", int'(partReset[2]), 0);

    // R5 acknowledge at the last allowed edge
    cfgWrite(0, 3, 2);
    cfgWrite(1, 0, 3);
    startPulse(3);
    tick(3);
    chk("R2 p3 preempt", int'(preemptReq[3]), 1);
    tick(3);
    chk("R5 still waiting", int'(preemptReq[3]), 1);
    preemptAck = 4'b1000;
    tick(1);
    preemptAck = '0;
    chk("R5 late ack accepted", int'(preemptReq[3] | partReset[3]), 0);
    tick(1);
    chk("R5 no reset", int'(partReset[3]), 0);

    // R9 R10 global watchdog
    kickerOn = 1'b0;
    tick(2);
    cfgWe = 1'b1; cfgSel = 2'd2; cfgData = 12'd30;
    kB = 1'b1; secB = 1'b1;
    tick(1);
    cfgWe = 1'b0; kB = 1'b0; secB = 1'b0;
    for (int i = 0; i < 30; i++) begin
      kB = (i % 3 == 0);
      tick(1);
    end
    kB = 1'b0;
    chk("R10 nonsecure ignored", int'(deviceReset), 0);
    chk("R10 error count", int'(kickErrCount), 10);
    tick(1);
    chk("R9 device reset", int'(deviceReset), 1);
    kB = 1'b1;
    tick(250);
    kB = 1'b0;
    tick(1);
    chk("R10 saturates", int'(kickErrCount), 255);
    kB = 1'b1; secB = 1'b1;
    tick(1);
    kB = 1'b0; secB = 1'b0;
    tick(1);
    chk("R9 sticky", int'(deviceReset), 1);
    chk("R10 secure not counted", int'(kickErrCount), 255);
    rstN = 1'b0;
    tick(2);
    rstN = 1'b1;
    tick(1);
    chk("R1 device reset cleared", int'(deviceReset), 0);
    chk("R1 error count cleared", int'(kickErrCount), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule